// File: doc/BRIEF.md
# Waveform Timer Channel

This block is one timer channel that generates waveforms. A counter, 16 bits wide by default, advances on every cycle where an outside clock-enable tick arrives while the channel clock is on. Three compare registers A, B and C are matched against the counter. The counter can count in four ways: upward only, up/down between zero and the top value, upward with a return to zero after reaching C, or up/down with the turn at C.

Two output pins are driven, tioa and tiob. Each pin has its own 2-bit action for each of four sources, and each action can leave the pin unchanged, set it, clear it or toggle it. For tioa the sources are the A compare, the C compare, an external event and a software trigger. For tiob the B compare takes the place of the A compare.

Software writes a control word, a mode word, the three compare values and an interrupt mask through a simple write port. It reads a status word whose event flags are cleared by a read strobe.

Top module: `wave_timer_chan`

## Requirements
- R1: The counter is CW bits wide (default 16) and resets to 0. In waveform 0 it adds 1 on each counting step and wraps from all-ones to 0. Each step taken upward from all-ones sets status bit 0 (overflow).
- R2: In waveform 2 the counter counts upward. On the step after it reaches the C value, it returns to 0.
- R3: In waveform 1 the counter turns from up to down at all-ones, and in waveform 3 it turns at the C value. In both waveforms it turns from down to up at 0.
- R4: A compare match happens on a counting step whose new count equals A, B or C. The match sets status bit 2, 3 or 4, and applies that pin's action for the source. Actions are encoded 0 none, 1 set, 2 clear, 3 toggle. Mode word fields: [1:0] waveform, [2] stop on C, [3] disable on C, [5:4] event edge, [7:6] event source, [8] event restarts, [10:9] tioa on A, [12:11] tioa on C, [14:13] tioa on event, [16:15] tioa on software trigger, [18:17] tiob on B, [20:19] tiob on C, [22:21] tiob on event, [24:23] tiob on software trigger.
- R5: Writing control (address 0) with bit 2 set issues a software trigger. Its pin actions take effect at that clock edge. The counter keeps its value until the next counting step, which loads 0 and sets the direction to up.
- R6: When several sources hit one pin in the same cycle, only the highest non-zero action is applied. The order, highest first, is: software trigger, external event, C compare, own compare (A or B).
- R7: Event source 0 is tiob_in and sources 1 to 3 are xc_in[0..2]. Event edge 0 is none, 1 rising, 2 falling and 3 both. A detected event sets status bit 7. When bit 8 of the mode word is set, the event also restarts the counter as in R5.
- R8: In control, bit 0 turns the channel clock on and bit 1 turns it off; bit 1 wins when both are set. Status bit 16 shows the clock state. The counter changes only on cycles with tick high.
- R9: With stop-on-C set, a C match halts counting until the next trigger, and the clock stays on. With disable-on-C set, a C match turns the clock off.
- R10: Status bits 0, 2, 3, 4 and 7 are sticky and are cleared by stat_rd; a new event in the same cycle wins. Status bits 17 and 18 show the tioa and tiob levels.
- R11: A write to address 5 sets the mask bits that are 1 in the data, and a write to address 6 clears them. irq is high when any status bit [7:0] is set and its mask bit is also set.
- R12: After reset, count, both pins, status and mask are all 0. The compare registers are written at addresses 2 (A), 3 (B) and 4 (C), and the mode word at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Counting clock-enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Write data |
| stat_rd | input | 1 | Status read strobe, clears event flags |
| xc_in | input | 3 | External event lines 0 to 2 |
| tiob_in | input | 1 | Sampled level of the B pin, used as event source 0 |
| status | output | 32 | Status word |
| count | output | CW | Counter value |
| tioa | output | 1 | Waveform pin A |
| tiob | output | 1 | Waveform pin B |
| irq | output | 1 | Interrupt request |

## Verification
A software trigger and an external event can reach the same pin in the same cycle. The bench provokes this by raising the selected event line at the same clock edge as the trigger write. The trigger's set action must win over the event's clear action, and the event flag must still be recorded. It then sends the event alone and expects the clear action. The bench also sweeps every software-trigger action against both starting levels on both pins. Every counting waveform is stepped count by count against sequences worked out in the bench, using an 8-bit counter.

// File: rtl/wt_pkg.sv
// Package: shared encodings and the mode word layout for the waveform timer channel.
// Assumes: the mode word is written as one 32-bit value; positions fixed by the brief.
package wt_pkg;

    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_MODE = 3'd1;
    localparam logic [2:0] ADR_RA   = 3'd2;
    localparam logic [2:0] ADR_RB   = 3'd3;
    localparam logic [2:0] ADR_RC   = 3'd4;
    localparam logic [2:0] ADR_IEN  = 3'd5;
    localparam logic [2:0] ADR_IDIS = 3'd6;

    localparam logic [1:0] WV_UP      = 2'd0;
    localparam logic [1:0] WV_UPDN    = 2'd1;
    localparam logic [1:0] WV_UP_C    = 2'd2;
    localparam logic [1:0] WV_UPDN_C  = 2'd3;

    localparam logic [1:0] ACT_NONE   = 2'd0;
    localparam logic [1:0] ACT_SET    = 2'd1;
    localparam logic [1:0] ACT_CLR    = 2'd2;
    localparam logic [1:0] ACT_TGL    = 2'd3;

    typedef struct packed {
        logic [6:0] spare;
        logic [1:0] b_sw;
        logic [1:0] b_ev;
        logic [1:0] b_c;
        logic [1:0] b_b;
        logic [1:0] a_sw;
        logic [1:0] a_ev;
        logic [1:0] a_c;
        logic [1:0] a_a;
        logic       ev_trig;
        logic [1:0] ev_src;
        logic [1:0] ev_edge;
        logic       dis_on_c;
        logic       stop_on_c;
        logic [1:0] wave;
    } mode_t;

endpackage

// File: rtl/wt_counter.sv
// Module: counting engine with direction state and a pending-restart latch.
// Assumes: step is high only when the channel is allowed to count; trig may come any cycle.
module wt_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          trig,
    input  logic [1:0]    wave,
    input  logic [CW-1:0] c_val,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nxt,
    output logic          pend,
    output logic          ovf
);
    import wt_pkg::*;

    localparam logic [CW-1:0] MAXV = {CW{1'b1}};
    localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

    logic          dir_up;
    logic          dir_nxt;
    logic [CW-1:0] top;

    // Purpose: pick the turning point for the up/down waveforms.
    always_comb top = (wave == WV_UPDN_C) ? c_val : MAXV;

    // Purpose: next count and direction for the selected waveform.
    always_comb begin
        cnt_nxt = cnt + ONE;
        dir_nxt = 1'b1;
        if (pend) begin
            cnt_nxt = '0;
            dir_nxt = 1'b1;
        end else begin
            case (wave)
                WV_UP_C: cnt_nxt = (cnt == c_val) ? '0 : cnt + ONE;
                WV_UPDN, WV_UPDN_C: begin
                    if (dir_up) begin
                        if (cnt == top || cnt == MAXV) begin
                            dir_nxt = 1'b0;
                            cnt_nxt = (cnt == '0) ? '0 : cnt - ONE;
                        end else begin
                            cnt_nxt = cnt + ONE;
                        end
                    end else begin
                        if (cnt == '0) begin
                            dir_nxt = 1'b1;
                            cnt_nxt = (top == '0) ? '0 : ONE;
                        end else begin
                            dir_nxt = 1'b0;
                            cnt_nxt = cnt - ONE;
                        end
                    end
                end
                default: cnt_nxt = cnt + ONE;
            endcase
        end
    end

    // Purpose: overflow is an upward step taken from all-ones.
    always_comb ovf = step && !pend && dir_up && (cnt == MAXV);

    // Purpose: hold count, direction and the pending restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_up <= 1'b1;
            pend   <= 1'b0;
        end else begin
            if (step) begin
                cnt    <= cnt_nxt;
                dir_up <= dir_nxt;
            end
            pend <= trig | (pend & ~step);
        end
    end

endmodule

// File: rtl/wt_evt_edge.sv
// Module: selects one of four event lines and detects the chosen edge on it.
// Assumes: the lines are already synchronous to clk.
module wt_evt_edge (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] lines,
    input  logic [1:0] sel,
    input  logic [1:0] edg,
    output logic       ev
);
    logic [3:0] prev;
    logic       now_l;
    logic       old_l;

    // Purpose: remember every line so a source change makes no false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lines;
    end

    // Purpose: edge bit 0 picks rising, bit 1 picks falling.
    always_comb begin
        now_l = lines[sel];
        old_l = prev[sel];
        ev    = (edg[0] & now_l & ~old_l) | (edg[1] & ~now_l & old_l);
    end

endmodule

// File: rtl/wt_pin.sv
// Module: one output pin with four prioritised action sources.
// Assumes: hit[3] is the highest priority source, hit[0] the lowest.
module wt_pin (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] hit,
    input  logic [7:0] act,
    output logic       lvl
);
    import wt_pkg::*;

    logic [1:0] pick;
    logic       lvl_nxt;

    // Purpose: the highest source with a non-zero action wins.
    always_comb begin
        pick = ACT_NONE;
        for (int i = 0; i < 4; i++) begin
            if (hit[i] && act[2*i +: 2] != ACT_NONE) pick = act[2*i +: 2];
        end
    end

    // Purpose: apply the chosen action to the pin level.
    always_comb begin
        case (pick)
            ACT_SET: lvl_nxt = 1'b1;
            ACT_CLR: lvl_nxt = 1'b0;
            ACT_TGL: lvl_nxt = ~lvl;
            default: lvl_nxt = lvl;
        endcase
    end

    // Purpose: pin level register.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl <= 1'b0;
        else        lvl <= lvl_nxt;
    end

endmodule

// File: rtl/wave_timer_chan.sv
// Module: waveform timer channel top with registers, status, mask and two pins.
// Assumes: tick comes from an outside prescaler; writes take effect at the next edge.
module wave_timer_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [31:0]   wr_data,
    input  logic          stat_rd,
    input  logic [2:0]    xc_in,
    input  logic          tiob_in,
    output logic [31:0]   status,
    output logic [CW-1:0] count,
    output logic          tioa,
    output logic          tiob,
    output logic          irq
);
    import wt_pkg::*;

    localparam int NPIN = 2;

    mode_t         mode;
    logic [CW-1:0] ra, rb, rc;
    logic [7:0]    mask;
    logic [7:0]    flags;
    logic [7:0]    new_flags;
    logic          clk_on;
    logic          stopped;
    logic          step;
    logic          pend;
    logic          ovf;
    logic [CW-1:0] cnt_nxt;
    logic          hit_a, hit_b, hit_c;
    logic          ev;
    logic          sw;
    logic          trig;
    logic [NPIN-1:0] pin_lvl;
    wire           unused_hi = ^{wr_data[31:25], mode.spare};

    // Purpose: decode write strobes for control.
    always_comb begin
        sw   = wr_en && (wr_addr == ADR_CTRL) && wr_data[2];
        trig = sw | (ev & mode.ev_trig);
        step = tick & clk_on & ~stopped;
    end

    // Purpose: configuration registers and interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
            ra   <= '0;
            rb   <= '0;
            rc   <= '0;
            mask <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_MODE: mode <= mode_t'(wr_data);
                ADR_RA:   ra   <= wr_data[CW-1:0];
                ADR_RB:   rb   <= wr_data[CW-1:0];
                ADR_RC:   rc   <= wr_data[CW-1:0];
                ADR_IEN:  mask <= mask | wr_data[7:0];
                ADR_IDIS: mask <= mask & ~wr_data[7:0];
                default:  ;
            endcase
        end
    end

    wt_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .trig    (trig),
        .wave    (mode.wave),
        .c_val   (rc),
        .cnt     (count),
        .cnt_nxt (cnt_nxt),
        .pend    (pend),
        .ovf     (ovf)
    );

    wt_evt_edge u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .lines ({xc_in, tiob_in}),
        .sel   (mode.ev_src),
        .edg   (mode.ev_edge),
        .ev    (ev)
    );

    // Purpose: compare matches on the value the counter steps onto.
    always_comb begin
        hit_a = step && (cnt_nxt == ra);
        hit_b = step && (cnt_nxt == rb);
        hit_c = step && (cnt_nxt == rc);
    end

    // Purpose: channel clock on/off; a control write overrides a C disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_on <= 1'b0;
        end else if (wr_en && wr_addr == ADR_CTRL && (wr_data[1] || wr_data[0])) begin
            clk_on <= ~wr_data[1];
        end else if (hit_c && mode.dis_on_c) begin
            clk_on <= 1'b0;
        end
    end

    // Purpose: halt after a C match in stop mode until a trigger arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)                        stopped <= 1'b0;
        else if (trig)                     stopped <= 1'b0;
        else if (hit_c && mode.stop_on_c)  stopped <= 1'b1;
    end

    // Purpose: sticky event flags, cleared by a status read, new events win.
    always_comb new_flags = {ev, 2'b00, hit_c, hit_b, hit_a, 1'b0, ovf};

    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (stat_rd ? 8'h00 : flags) | new_flags;
    end

    // Purpose: two pins built from one prioritised action cell.
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [3:0] hit_v;
        logic [7:0] act_v;
        if (p == 0) begin : g_a
            assign hit_v = {sw, ev, hit_c, hit_a};
            assign act_v = {mode.a_sw, mode.a_ev, mode.a_c, mode.a_a};
        end else begin : g_b
            assign hit_v = {sw, ev, hit_c, hit_b};
            assign act_v = {mode.b_sw, mode.b_ev, mode.b_c, mode.b_b};
        end
        wt_pin u_pin (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit_v),
            .act   (act_v),
            .lvl   (pin_lvl[p])
        );
    end

    // Purpose: drive pins, status word and interrupt.
    always_comb begin
        tioa   = pin_lvl[0];
        tiob   = pin_lvl[1];
        status = {13'b0, pin_lvl[1], pin_lvl[0], clk_on, 8'b0, flags};
        irq    = |(flags & mask);
    end

endmodule

// File: rtl/wt_chk.sv
// Module: property checker bound to the waveform timer channel.
// Assumes: connected to the top's ports and to a few of its internal nets.
module wt_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          wr_en,
    input logic [2:0]    wr_addr,
    input logic [31:0]   wr_data,
    input logic [CW-1:0] count,
    input logic          pend,
    input logic          step,
    input logic [1:0]    wave,
    input logic [1:0]    a_sw,
    input logic [CW-1:0] rc,
    input logic          tioa,
    input logic [31:0]   status,
    input logic          irq
);
    import wt_pkg::*;

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !pend && wave == WV_UP) |=> count == CW'($past(count) + 1'b1)); // R1
    AST_AUTO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !pend && wave == WV_UP_C && count == rc) |=> count == '0); // R2
    AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_CTRL && wr_data[2] && a_sw == ACT_SET) |=> tioa); // R5
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count)); // R8
    AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_CTRL && wr_data[1]) |=> !status[16]); // R8
    AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_IDIS && wr_data[7:0] == 8'hFF) |=> !irq); // R11

endmodule

bind wave_timer_chan wt_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .count   (count),
    .pend    (pend),
    .step    (step),
    .wave    (mode.wave),
    .a_sw    (mode.a_sw),
    .rc      (rc),
    .tioa    (tioa),
    .status  (status),
    .irq     (irq)
);

// File: tb/tb_wave_timer_chan.sv
// Bench: drives the channel with an 8-bit counter and checks every requirement.
module tb_wave_timer_chan;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          stat_rd = 1'b0;
    logic [2:0]    xc_in = '0;
    logic          tiob_in = 1'b0;
    logic [31:0]   status;
    logic [CW-1:0] count;
    logic          tioa, tiob, irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    wave_timer_chan #(.CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .stat_rd(stat_rd), .xc_in(xc_in), .tiob_in(tiob_in),
        .status(status), .count(count), .tioa(tioa), .tiob(tiob), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic step1();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    function automatic logic [31:0] mm(int wv, int stp, int dis, int edg, int src, int trg,
                                       int aa, int ac, int aev, int asw,
                                       int bb, int bc, int bev, int bsw);
        return 32'(wv) | 32'(stp) << 2 | 32'(dis) << 3 | 32'(edg) << 4 | 32'(src) << 6 |
               32'(trg) << 8 | 32'(aa) << 9 | 32'(ac) << 11 | 32'(aev) << 13 | 32'(asw) << 15 |
               32'(bb) << 17 | 32'(bc) << 19 | 32'(bev) << 21 | 32'(bsw) << 23;
    endfunction

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic exp_l;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 count", 32'(count), 0);
        chk("R12 status", status, 0);
        chk("R12 pins", {30'b0, tiob, tioa}, 0);
        chk("R12 irq", 32'(irq), 0);

        // R4 / R1: up count with compare actions
        wr(3'd2, 3); wr(3'd3, 5); wr(3'd4, 6);
        wr(3'd1, mm(0,0,0,0,0,0, 1,2,0,0, 3,0,0,0));
        wr(3'd0, 1);
        for (int i = 1; i <= 6; i++) begin
            step1();
            chk("R1 up count", 32'(count), 32'(i));
            chk("R4 tioa level", 32'(tioa), 32'(i >= 3 && i < 6));
            chk("R4 tiob toggle", 32'(tiob), 32'(i >= 5));
        end
        chk("R4 compare flags", {27'b0, status[4:2], 2'b0}, 32'h1C);
        chk("R10 pin mirror", {29'b0, status[18:16]}, 32'h5);
        rd();
        chk("R10 read clears", 32'(status[7:0]), 0);
        for (int i = 0; i < 250; i++) step1();
        chk("R1 wrap to zero", 32'(count), 0);
        chk("R1 overflow flag", 32'(status[0]), 1);
        step1(); step1();

        // R5 software trigger sweep on both pins
        for (int p = 0; p < 2; p++) begin
            for (int pre = 0; pre < 2; pre++) begin
                for (int a = 0; a < 4; a++) begin
                    int k;
                    k = pre ? 1 : 2;
                    wr(3'd1, p == 0 ? mm(0,0,0,0,0,0, 0,0,0,k, 0,0,0,0)
                                    : mm(0,0,0,0,0,0, 0,0,0,0, 0,0,0,k));
                    wr(3'd0, 4);
                    wr(3'd1, p == 0 ? mm(0,0,0,0,0,0, 0,0,0,a, 0,0,0,0)
                                    : mm(0,0,0,0,0,0, 0,0,0,0, 0,0,0,a));
                    wr(3'd0, 4);
                    exp_l = (a == 0) ? pre[0] : (a == 1) ? 1'b1 : (a == 2) ? 1'b0 : ~pre[0];
                    chk("R5 sw action", 32'(p == 0 ? tioa : tiob), 32'(exp_l));
                end
            end
        end
        chk("R5 count held before tick", 32'(count), 2);
        step1();
        chk("R5 restart on tick", 32'(count), 0);

        // R6 priority: software trigger beats external event
        wr(3'd1, mm(0,0,0,0,0,0, 0,0,0,2, 0,0,0,0));
        wr(3'd0, 4);
        wr(3'd1, mm(0,0,0,1,1,0, 0,0,2,1, 0,0,0,0));
        rd();
        @(negedge clk); xc_in[0] = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 4;
        @(negedge clk); wr_en = 1'b0;
        chk("R6 sw wins", 32'(tioa), 1);
        chk("R7 event flag", 32'(status[7]), 1);
        @(negedge clk); xc_in[0] = 1'b0;
        @(negedge clk);
        chk("R6 falling unselected", 32'(tioa), 1);
        @(negedge clk); xc_in[0] = 1'b1;
        @(negedge clk);
        chk("R6 event alone clears", 32'(tioa), 0);

        // R7 event source sweep with both edges
        for (int s = 0; s < 4; s++) begin
            wr(3'd1, mm(0,0,0,3,s,0, 0,0,0,0, 0,0,0,0));
            rd();
            @(negedge clk);
            if (s == 0) tiob_in = ~tiob_in; else xc_in[s-1] = ~xc_in[s-1];
            @(negedge clk);
            chk("R7 source select", 32'(status[7]), 1);
        end

        // R7 event as restart (falling edge on xc2)
        xc_in = 3'b000;
        wr(3'd1, mm(0,0,0,2,3,1, 0,0,0,0, 0,0,0,0));
        step1(); step1(); step1();
        chk("R7 pre-event count", 32'(count), 2);
        @(negedge clk); xc_in[2] = 1'b1;
        @(negedge clk); xc_in[2] = 1'b0;
        @(negedge clk);
        chk("R7 count held", 32'(count), 2);
        step1();
        chk("R7 event restart", 32'(count), 0);

        // R2 auto reset on C
        wr(3'd2, 200); wr(3'd3, 200); wr(3'd4, 4);
        wr(3'd1, mm(2,0,0,0,0,0, 0,0,0,0, 0,0,0,0));
        wr(3'd0, 4); step1();
        for (int i = 1; i <= 7; i++) begin
            step1();
            chk("R2 auto reset", 32'(count), 32'(i % 5));
        end

        // R3 up/down with turn at C
        wr(3'd4, 3);
        wr(3'd1, mm(3,0,0,0,0,0, 0,0,0,0, 0,0,0,0));
        wr(3'd0, 4); step1();
        for (int i = 1; i <= 8; i++) begin
            int e;
            e = (i <= 3) ? i : (i <= 6) ? 6 - i : i - 6;
            step1();
            chk("R3 updown at C", 32'(count), 32'(e));
        end

        // R3 up/down with turn at all-ones
        wr(3'd1, mm(1,0,0,0,0,0, 0,0,0,0, 0,0,0,0));
        wr(3'd0, 4); step1();
        for (int i = 0; i < 255; i++) step1();
        chk("R3 reach top", 32'(count), 255);
        rd();
        step1();
        chk("R3 turn at top", 32'(count), 254);
        chk("R1 overflow at turn", 32'(status[0]), 1);
        step1();
        chk("R3 counting down", 32'(count), 253);

        // R9 stop on C
        wr(3'd4, 2);
        wr(3'd1, mm(0,1,0,0,0,0, 0,0,0,0, 0,0,0,0));
        wr(3'd0, 4); step1(); step1(); step1();
        chk("R9 stop reached C", 32'(count), 2);
        step1();
        chk("R9 stop holds", 32'(count), 2);
        chk("R9 clock still on", 32'(status[16]), 1);
        wr(3'd0, 4); step1();
        chk("R9 trigger resumes", 32'(count), 0);

        // R9 / R8 disable on C
        wr(3'd1, mm(0,0,1,0,0,0, 0,0,0,0, 0,0,0,0));
        step1(); step1();
        chk("R9 disable clears clock", 32'(status[16]), 0);
        step1();
        chk("R8 no count when off", 32'(count), 2);
        wr(3'd0, 1); step1();
        chk("R8 enable counts", 32'(count), 3);
        wr(3'd0, 3);
        chk("R8 disable wins", 32'(status[16]), 0);

        // R11 interrupt mask
        wr(3'd1, mm(0,0,0,0,0,0, 0,0,0,0, 0,0,0,0));
        wr(3'd4, 4);
        wr(3'd0, 1);
        rd();
        wr(3'd5, 32'h10);
        chk("R11 masked idle", 32'(irq), 0);
        step1();
        chk("R11 irq on C", 32'(irq), 1);
        wr(3'd6, 32'h10);
        chk("R11 mask cleared", 32'(irq), 0);
        chk("R11 flag kept", 32'(status[4]), 1);
        wr(3'd5, 32'h10);
        chk("R11 mask reset", 32'(irq), 1);
        rd();
        chk("R10 read drops irq", 32'(irq), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule